// File: doc/BRIEF.md
# Pixel Component Extraction Unit

This block sits in a streaming RGB display path between the pixel fetch logic and the output timing stage. Each cycle it may receive one 32-bit framebuffer word. A pixel-size setting picks how many of the word's low-order bytes form the pixel. The bytes are little-endian, so byte 0 is the least significant. For each of the red, green and blue channels a select word gives three values: the lowest bit of the field to take, how many bits to take, and a fallback value. The field that is taken is scaled to an 8-bit color by left-alignment.

The fallback value replaces pixel data in three cases: the pixel lies outside the visible area, the pixel source has underrun, or the channel's width is zero. A fallback of full red on the red channel therefore shows underruns on screen. Configuration is loaded through a simple write port. The result is registered, and a small state machine classifies every output cycle into one of three states. SHOW_IDLE means no pixel and zero colors. SHOW_PIXEL means extracted data. SHOW_BLANK means fallback colors. There are three transitions, all decided from the current input each cycle. The state goes to SHOW_IDLE when `pix_valid` is low. It goes to SHOW_BLANK when a valid pixel is inactive or has underrun. It goes to SHOW_PIXEL when a valid pixel is active and clean. Any state may follow any other.

Top module: `pixel_extract`

## Requirements
- R1: After reset, `rgb_valid` is 0 and all colors are 0. The pixel size is 1 byte and every channel select word is 0 (width 0, fallback 0).
- R2: `rgb_valid` equals `pix_valid` delayed by exactly one clock cycle.
- R3: While `rgb_valid` is 0, `rgb_r`, `rgb_g` and `rgb_b` are all 0.
- R4: A write to address 0 sets the pixel size to (wdata[4:3] + 1) bytes. The pixel is the low bytes of `pix_word`, with byte 0 least significant. Bits above the pixel size read as zero.
- R5: Addresses 1, 2 and 3 hold the red, green and blue select words. In each word, bits 4:0 give the lowest extracted bit, bits 11:8 give the width (0 to 15), and bits 23:16 give the fallback value.
- R6: With width w from 1 to 7, the output's top w bits are the field, and the lower bits are filled by repeating the field from its most significant bit down. With w of 8 or more, the output is the field's top 8 bits.
- R7: A channel whose width is 0 outputs its fallback value for every valid pixel.
- R8: A valid pixel with `pix_active` low outputs the fallback value on all three channels.
- R9: A valid pixel with `pix_underrun` high outputs the fallback value on all three channels, even when `pix_active` is high.
- R10: When `cfg_we` is low, `cfg_addr` and `cfg_wdata` have no effect on any later output.
- R11: A pixel sampled on the same clock edge as a configuration write uses the old configuration. A pixel sampled on the next edge uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Register address (0 size, 1 red, 2 green, 3 blue) |
| cfg_wdata | input | 32 | Configuration write data |
| pix_valid | input | 1 | Pixel word present this cycle |
| pix_underrun | input | 1 | Pixel source has run dry this cycle |
| pix_active | input | 1 | Pixel lies inside the visible area |
| pix_word | input | 32 | Raw framebuffer data |
| rgb_valid | output | 1 | Output colors valid |
| rgb_r | output | 8 | Red component |
| rgb_g | output | 8 | Green component |
| rgb_b | output | 8 | Blue component |

## Verification
The fallback properties compare each output with the select word held one cycle earlier. They assume that the configuration a pixel sees is the one present at the edge on which that pixel is sampled. The validity properties assume `pix_valid` is low during reset. The stimulus drives all inputs on the falling edge, keeps `pix_valid` low while reset is applied, and mixes random configuration writes with random pixels. One directed case writes the configuration and presents a pixel on the same edge, so that the old-configuration rule is exercised.

// File: rtl/pxext_pkg.sv
package pxext_pkg;
    localparam int COLOR_W = 8;
    localparam int WORD_W  = 32;
    localparam int CHANS   = 3;

    typedef struct packed {
        logic [7:0] dflt;
        logic [3:0] width;
        logic [4:0] lsb;
    } chan_sel_t;

    typedef enum logic [1:0] {
        SHOW_IDLE  = 2'd0,
        SHOW_PIXEL = 2'd1,
        SHOW_BLANK = 2'd2
    } show_e;

    // Scale a right-justified field of the given width to a full color.
    function automatic logic [COLOR_W-1:0] left_align(logic [WORD_W-1:0] field,
                                                      logic [3:0] width);
        logic [COLOR_W-1:0] r;
        logic [3:0] idx;
        r = '0;
        if (width >= 4'd8) begin
            r = COLOR_W'(field >> (width - 4'd8));
        end else if (width != 4'd0) begin
            idx = width - 4'd1;
            for (int i = COLOR_W - 1; i >= 0; i--) begin
                r[i] = field[idx];
                idx  = (idx == 4'd0) ? width - 4'd1 : idx - 4'd1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pxext_cfg.sv
module pxext_cfg
    import pxext_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [1:0]        bpp_m1,
    output chan_sel_t         sel [CHANS]
);
    localparam int SIZE_LSB = 3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpp_m1 <= '0;
        end else if (we && addr == ADDR_W'(0)) begin
            bpp_m1 <= wdata[SIZE_LSB +: 2];
        end
    end

    for (genvar c = 0; c < CHANS; c++) begin : g_sel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel[c] <= '0;
            end else if (we && addr == ADDR_W'(c + 1)) begin
                sel[c].dflt  <= wdata[23:16];
                sel[c].width <= wdata[11:8];
                sel[c].lsb   <= wdata[4:0];
            end
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{wdata[DATA_W-1:24], wdata[15:12], wdata[7:5]};
endmodule

// File: rtl/pxext_chan.sv
module pxext_chan
    import pxext_pkg::*;
(
    input  logic [WORD_W-1:0]  pixel,
    input  chan_sel_t          sel,
    output logic [COLOR_W-1:0] color,
    output logic               zero_w
);
    always_comb begin
        color  = left_align(pixel >> sel.lsb, sel.width);
        zero_w = (sel.width == 4'd0);
    end
endmodule

// File: rtl/pixel_extract.sv
module pixel_extract
    import pxext_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              pix_valid,
    input  logic              pix_underrun,
    input  logic              pix_active,
    input  logic [31:0]       pix_word,
    output logic              rgb_valid,
    output logic [7:0]        rgb_r,
    output logic [7:0]        rgb_g,
    output logic [7:0]        rgb_b
);
    logic [1:0]                    bpp_m1;
    chan_sel_t                     sel [CHANS];
    logic [WORD_W-1:0]             pixel;
    logic [5:0]                    nbits;
    logic [CHANS-1:0][COLOR_W-1:0] ext;
    logic [CHANS-1:0]              zero_w;
    logic [CHANS-1:0][COLOR_W-1:0] ch_dflt;
    logic [CHANS-1:0][3:0]         ch_width;
    logic [CHANS-1:0][COLOR_W-1:0] col_q;
    show_e                         state_q, state_d;

    pxext_cfg #(.ADDR_W(ADDR_W), .DATA_W(32)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .bpp_m1 (bpp_m1),
        .sel    (sel)
    );

    // Little-endian pixel: keep only the low bytes of the word.
    always_comb begin
        nbits = 6'(bpp_m1) * 6'd8 + 6'd8;
        pixel = (nbits >= 6'd32) ? pix_word
                                 : pix_word & ((32'd1 << nbits) - 32'd1);
    end

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        pxext_chan u_chan (
            .pixel  (pixel),
            .sel    (sel[c]),
            .color  (ext[c]),
            .zero_w (zero_w[c])
        );
        assign ch_dflt[c]  = sel[c].dflt;
        assign ch_width[c] = sel[c].width;
    end

    always_comb begin
        if (!pix_valid)                        state_d = SHOW_IDLE;
        else if (!pix_active || pix_underrun)  state_d = SHOW_BLANK;
        else                                   state_d = SHOW_PIXEL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SHOW_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            unique case (state_d)
                SHOW_IDLE:  col_q <= '0;
                SHOW_BLANK: col_q <= ch_dflt;
                SHOW_PIXEL: begin
                    for (int c = 0; c < CHANS; c++)
                        col_q[c] <= zero_w[c] ? ch_dflt[c] : ext[c];
                end
                default:    col_q <= '0;
            endcase
        end
    end

    assign rgb_valid = (state_q != SHOW_IDLE);
    assign rgb_r     = col_q[0];
    assign rgb_g     = col_q[1];
    assign rgb_b     = col_q[2];
endmodule

// File: rtl/pixel_extract_chk.sv
module pixel_extract_chk (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             pix_active,
    input logic             pix_underrun,
    input logic             rgb_valid,
    input logic [7:0]       rgb_r,
    input logic [7:0]       rgb_g,
    input logic [7:0]       rgb_b,
    input logic [2:0][7:0]  ch_dflt,
    input logic [2:0][3:0]  ch_width
);
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> rgb_valid);
    a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !rgb_valid);
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rgb_valid |-> (rgb_r == 8'd0 && rgb_g == 8'd0 && rgb_b == 8'd0));
    a_r8_blank_default: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_active) |=> {rgb_b, rgb_g, rgb_r} == $past(ch_dflt));
    a_r9_underrun_default: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_underrun) |=> {rgb_b, rgb_g, rgb_b} == {$past(ch_dflt[2]), $past(ch_dflt[1]), $past(ch_dflt[2])}
            && rgb_r == $past(ch_dflt[0]));
    a_r7_zero_width_red: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ch_width[0] == 4'd0) |=> rgb_r == $past(ch_dflt[0]));
    a_r7_zero_width_blue: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ch_width[2] == 4'd0) |=> rgb_b == $past(ch_dflt[2]));
endmodule

bind pixel_extract pixel_extract_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .pix_active   (pix_active),
    .pix_underrun (pix_underrun),
    .rgb_valid    (rgb_valid),
    .rgb_r        (rgb_r),
    .rgb_g        (rgb_g),
    .rgb_b        (rgb_b),
    .ch_dflt      (ch_dflt),
    .ch_width     (ch_width)
);

// File: tb/tb_pixel_extract.sv
module tb_pixel_extract;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        pix_valid, pix_underrun, pix_active;
    logic [31:0] pix_word;
    logic        rgb_valid;
    logic [7:0]  rgb_r, rgb_g, rgb_b;

    int total = 0;
    int bad   = 0;
    int          sh_bm1;
    logic [31:0] sh_sel [3];

    always #2 clk = ~clk;

    pixel_extract dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_underrun(pix_underrun),
        .pix_active(pix_active), .pix_word(pix_word), .rgb_valid(rgb_valid),
        .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
    );

    // Reference: repeat the field until it spans 8 bits, keep the top 8.
    function automatic logic [7:0] mdl(logic [31:0] word, int bm1, logic [31:0] s,
                                       bit vld, bit act, bit und);
        logic [63:0] px, v, acc;
        int w, off, len;
        if (!vld) return 8'd0;
        w   = int'(s[11:8]);
        off = int'(s[4:0]);
        if (!act || und || w == 0) return s[23:16];
        px  = {32'd0, word} & ((64'd1 << (8 * (bm1 + 1))) - 64'd1);
        v   = (px >> off) & ((64'd1 << w) - 64'd1);
        acc = v;
        len = w;
        while (len < 8) begin
            acc = (acc << w) | v;
            len = len + w;
        end
        return 8'(acc >> (len - 8));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shadow_write(logic [1:0] a, logic [31:0] d);
        if (a == 2'd0) sh_bm1 = int'(d[4:3]);
        else           sh_sel[a - 1] = d;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_write(a, d);
    endtask

    // Drive one pixel on a falling edge; check it on the next falling edge.
    task automatic pix(string req, logic [31:0] w, bit v, bit a, bit u);
        logic [7:0] er, eg, eb;
        pix_word = w; pix_valid = v; pix_active = a; pix_underrun = u;
        er = mdl(w, sh_bm1, sh_sel[0], v, a, u);
        eg = mdl(w, sh_bm1, sh_sel[1], v, a, u);
        eb = mdl(w, sh_bm1, sh_sel[2], v, a, u);
        @(negedge clk);
        pix_valid = 1'b0;
        check({req, " valid"}, 32'(rgb_valid), 32'(v));
        check({req, " red"},   32'(rgb_r), 32'(er));
        check({req, " green"}, 32'(rgb_g), 32'(eg));
        check({req, " blue"},  32'(rgb_b), 32'(eb));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] er;
        void'($urandom(32'd4711));
        sh_bm1 = 0;
        for (int i = 0; i < 3; i++) sh_sel[i] = '0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        pix_valid = 1'b0; pix_active = 1'b0; pix_underrun = 1'b0; pix_word = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 valid", 32'(rgb_valid), 32'd0);
        check("R1 colors", {8'd0, rgb_r, rgb_g, rgb_b}, 32'd0);
        // R1/R7: reset select words have width 0, fallback 0
        pix("R1 R7 reset config", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
        // R4 R5 R6: 2-byte 5-6-5 layout
        wr(2'd0, 32'd1 << 3);
        wr(2'd1, 32'h0000_050B);
        wr(2'd2, 32'h0000_0605);
        wr(2'd3, 32'h0000_0500);
        pix("R4 R6 565 white", 32'hABCD_FFFF, 1'b1, 1'b1, 1'b0);
        pix("R6 565 mixed", 32'h1234_A5C3, 1'b1, 1'b1, 1'b0);
        // R3 idle
        pix("R3 idle", 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);
        // R8 blank, R9 underrun with fallback
        wr(2'd1, 32'h00FF_050B);
        wr(2'd3, 32'h0033_0500);
        pix("R8 inactive", 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
        pix("R9 underrun", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
        // R4: 1-byte pixel hides bits above byte 0
        wr(2'd0, 32'd0);
        wr(2'd1, 32'h0000_0804);
        pix("R4 one byte masked", 32'hFFFF_FF0F, 1'b1, 1'b1, 1'b0);
        // R6: width 12 and width 1 and width 3
        wr(2'd0, 32'd3 << 3);
        wr(2'd1, 32'h0000_0C10);
        wr(2'd2, 32'h0000_011F);
        wr(2'd3, 32'h0000_0302);
        pix("R6 wide narrow", 32'h8ABC_0014, 1'b1, 1'b1, 1'b0);
        // R10: writes with enable low ignored
        cfg_addr = 2'd1; cfg_wdata = 32'h0077_0000;
        @(negedge clk);
        cfg_addr = 2'd0; cfg_wdata = 32'd0;
        @(negedge clk);
        pix("R10 ignored write", 32'h8ABC_0014, 1'b1, 1'b1, 1'b0);
        // R11: write and pixel on the same edge use the old setting
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h0055_0000;
        er = mdl(32'hFFFF_FFFF, sh_bm1, sh_sel[0], 1'b1, 1'b1, 1'b0);
        pix_word = 32'hFFFF_FFFF; pix_valid = 1'b1; pix_active = 1'b1; pix_underrun = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; pix_valid = 1'b0;
        shadow_write(2'd1, 32'h0055_0000);
        check("R11 old config", 32'(rgb_r), 32'(er));
        pix("R11 new config", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
        // Random mix (R2 R4 R5 R6 R7 R8 R9)
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0)
                wr(2'($urandom_range(0, 3)), $urandom);
            pix("R2 R6 random", $urandom, 1'($urandom_range(0, 7) != 0),
                1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 7) == 0));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule